// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block produces the column address for every beat of a single SDRAM read or write burst. When a start strobe arrives with a start column and a 4-bit mode value, it latches them. From the next cycle on it presents one column per clock, together with a valid flag and a final-beat flag. The mode value selects the burst length and the wrap order. The sequencer does not drive the data path, the bus turnaround or the command bus. A controller places it beside the command logic and uses its output as the column stream for a burst.

Burst lengths of 1, 2, 4 and 8 beats wrap inside an aligned block of that size. The wrap order is either sequential (add the beat number) or interleaved (XOR the beat number). A full-page burst walks the whole 512-column row in sequential order and wraps at the end of the row. It has no natural end and runs until a stop request or a new start. A new start can land in any cycle, including in the middle of a burst, and restarts the sequence at once. An invalid mode falls back to one beat and sets an error flag.

Top module: `sdram_burst_colseq`

## Requirements
- R1: After reset, `valid`, `last` and `cfg_err` are low, and they stay low until the first `start`.
- R2: A `start` in cycle n gives `valid` high in cycle n+1 with `col` equal to the sampled `start_col`. The length field `mode[2:0]` selects the number of beats: 000 gives 1, 001 gives 2, 010 gives 4, 011 gives 8.
- R3: With `mode[3]`=0 (sequential), beat k has its low log2(L) column bits equal to (start + k) mod L. All column bits above that field keep the start column's value.
- R4: With `mode[3]`=1 (interleaved), beat k has its low log2(L) bits equal to the start's low bits XOR k. The upper bits are unchanged. For example, start 5 with length 8 gives 5,4,7,6,1,0,3,2.
- R5: For lengths 1, 2, 4 and 8, `last` is high only on beat L-1. `valid` is low in the cycle after that beat unless a new `start` was given.
- R6: The length code 111 with sequential order gives a full-page burst. The column steps through all 512 values and wraps from 511 to 0. `last` never goes high, and `valid` stays high until a stop or a new start.
- R7: A `start` while a burst is active drops that burst. The next cycle shows beat 0 of the new burst, with the new column and the new mode.
- R8: A `stop` without `start` makes `valid` low in the next cycle. When `start` and `stop` are high in the same cycle, `start` wins.
- R9: The reserved length codes 100, 101 and 110, and the code 111 with interleaving, all give a one-beat burst at the start column with `cfg_err` high. `cfg_err` keeps the state set by the most recent `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a burst with `start_col` and `mode` |
| start_col | input | COL_W | First column of the burst |
| mode | input | 4 | Bit 3 selects the wrap order, bits 2:0 the length code |
| stop | input | 1 | End the running burst |
| col | output | COL_W | Column of the current beat |
| valid | output | 1 | A beat is presented this cycle |
| last | output | 1 | Final beat of a fixed-length burst |
| cfg_err | output | 1 | The mode of the latest start was not usable |

## Verification
The two functions that can fall in the same cycle are a new start and the end of a burst. The end can come either from a stop request or from the final beat of a fixed-length burst. The bench raises `start` together with `stop`, and also exactly on a beat that has `last` high, both in directed sequences and through random strobes. It judges each cycle against a cycle-level model that gives `start` priority, so the expected result is beat 0 of the new burst, never an idle cycle.

// File: rtl/sdram_burst_colseq.sv
module sdram_burst_colseq #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [3:0]       mode,
  input  logic             stop,
  output logic [COL_W-1:0] col,
  output logic             valid,
  output logic             last,
  output logic             cfg_err
);
  localparam logic [COL_W-1:0] ALL_ONES = '1;

  logic             act_q, il_q, fp_q, err_q;
  logic [COL_W-1:0] base_q, beat_q, mask_q;
  logic [COL_W-1:0] mask_d, wrap_bits;
  logic             fp_d, err_d, at_end;

  always_comb begin
    mask_d = '0;
    fp_d   = 1'b0;
    err_d  = 1'b0;
    case (mode[2:0])
      3'b000: mask_d = COL_W'(0);
      3'b001: mask_d = COL_W'(1);
      3'b010: mask_d = COL_W'(3);
      3'b011: mask_d = COL_W'(7);
      3'b111: begin
        if (mode[3]) err_d = 1'b1;
        else begin
          mask_d = ALL_ONES;
          fp_d   = 1'b1;
        end
      end
      default: err_d = 1'b1;
    endcase
  end

  assign wrap_bits = il_q ? (base_q ^ beat_q) : (base_q + beat_q);
  assign at_end    = !fp_q && (beat_q == mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      il_q   <= 1'b0;
      fp_q   <= 1'b0;
      err_q  <= 1'b0;
      base_q <= '0;
      beat_q <= '0;
      mask_q <= '0;
    end else if (start) begin
      act_q  <= 1'b1;
      il_q   <= mode[3] && !err_d;
      fp_q   <= fp_d;
      err_q  <= err_d;
      base_q <= start_col;
      beat_q <= '0;
      mask_q <= mask_d;
    end else if (act_q) begin
      if (stop || at_end) act_q <= 1'b0;
      else                beat_q <= beat_q + 1'b1;
    end
  end

  assign col     = (base_q & ~mask_q) | (wrap_bits & mask_q);
  assign valid   = act_q;
  assign last    = act_q && at_end;
  assign cfg_err = err_q;
endmodule

// File: rtl/sdram_burst_colseq_chk.sv
module sdram_burst_colseq_chk #(
  parameter int COL_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [COL_W-1:0] start_col,
  input logic             stop,
  input logic [COL_W-1:0] col,
  input logic             valid,
  input logic             last,
  input logic             cfg_err
);
  a_r2_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (valid && col == $past(start_col)));

  a_r8_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !start) |=> !valid);

  a_r5_last_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
    last |-> valid);

  a_r5_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !start) |=> !valid);

  a_r9_err_single_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && valid) |-> last);
endmodule

bind sdram_burst_colseq sdram_burst_colseq_chk #(.COL_W(COL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col), .stop(stop),
  .col(col), .valid(valid), .last(last), .cfg_err(cfg_err)
);

// File: tb/tb_sdram_burst_colseq.sv
`timescale 1ns/1ps
module tb_sdram_burst_colseq;
  localparam int COL_W = 9;
  localparam int PAGE  = 512;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic [3:0]       mode = '0;
  logic             stop = 1'b0;
  logic [COL_W-1:0] col;
  logic             valid, last, cfg_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  string tag_v = "R2";

  always #4 clk = ~clk;

  sdram_burst_colseq #(.COL_W(COL_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col), .mode(mode),
    .stop(stop), .col(col), .valid(valid), .last(last), .cfg_err(cfg_err)
  );

  // cycle-level expectation
  bit m_act, m_il, m_err;
  int m_base, m_beat, m_len;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_err = 0; m_beat = 0; m_len = 1; m_il = 0; m_base = 0;
    end else if (start) begin
      m_act = 1; m_beat = 0; m_base = int'(start_col); m_il = mode[3]; m_err = 0;
      if (mode[2:0] <= 3)       m_len = 1 << mode[2:0];
      else if (mode[2:0] == 7 && !mode[3]) m_len = PAGE;
      else begin m_len = 1; m_err = 1; m_il = 0; end
    end else if (m_act) begin
      if (stop) m_act = 0;
      else if (m_len != PAGE && m_beat == m_len - 1) m_act = 0;
      else m_beat = (m_beat + 1) % PAGE;
    end
  end

  function automatic int exp_col(int b, int k, int len, bit il);
    int hi, lo;
    hi = b - (b % len);
    lo = b % len;
    return il ? hi + (lo ^ k) : hi + ((lo + k) % len);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp, string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    string tc;
    bit el;
    tc = m_err ? "R9" : (m_len == PAGE ? "R6" : (m_il ? "R4" : "R3"));
    el = m_act && m_len != PAGE && m_beat == m_len - 1;
    chk(valid == m_act, tag_v, valid, m_act, "valid");
    chk(last == el, (m_len == PAGE) ? "R6" : "R5", last, el, "last");
    chk(cfg_err == m_err, "R9", cfg_err, m_err, "cfg_err");
    if (m_act) chk(int'(col) == exp_col(m_base, m_beat, m_len, m_il), tc, col,
                   exp_col(m_base, m_beat, m_len, m_il), "col");
  endtask

  task automatic cyc(bit s, int c, bit [3:0] m, bit sp);
    @(negedge clk);
    if (rst_n) compare();
    start = s; start_col = COL_W'(c); mode = m; stop = sp;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 4'h0, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state and quiet until first start
    tag_v = "R1";
    idle(3);
    tag_v = "R2";
    // R3 example: seq len8 from 5; R4 interleave len8 from 5
    cyc(1, 5, 4'b0011, 0); idle(9);
    cyc(1, 5, 4'b1011, 0); idle(9);
    cyc(1, 37, 4'b0010, 0); idle(5);
    cyc(1, 38, 4'b1001, 0); idle(3);
    cyc(1, 100, 4'b0000, 0); idle(2);
    // R6: full page wraparound, no last
    cyc(1, 508, 4'b0111, 0); idle(12);
    tag_v = "R8"; cyc(0, 0, 0, 1); idle(2);
    // R6 full walk of the page
    tag_v = "R6";
    cyc(1, 3, 4'b0111, 0); idle(PAGE + 4);
    tag_v = "R8"; cyc(0, 0, 0, 1); idle(2);
    // R9 reserved codes and interleave with full page
    tag_v = "R9";
    cyc(1, 77, 4'b0100, 0); idle(2);
    cyc(1, 78, 4'b0101, 0); idle(1);
    cyc(1, 79, 4'b1110, 0); idle(1);
    cyc(1, 80, 4'b1111, 0); idle(2);
    cyc(1, 81, 4'b0001, 0); idle(3);
    // R7 restart mid-burst and on the last beat
    tag_v = "R7";
    cyc(1, 16, 4'b0011, 0); idle(3);
    cyc(1, 202, 4'b1010, 0); idle(3);
    cyc(1, 300, 4'b0001, 0); idle(5);
    // R8 start and stop together: start wins
    tag_v = "R8";
    cyc(1, 40, 4'b0011, 0); idle(2);
    cyc(1, 50, 4'b0010, 1); idle(1);
    cyc(0, 0, 0, 1); idle(3);
    tag_v = "R2";
    // random mix
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 20000; i++) begin
      bit s, sp;
      s  = (!m_act) ? ($urandom % 3 != 0) : ($urandom % 12 == 0);
      sp = ($urandom % 25 == 0);
      cyc(s, $urandom % PAGE, 4'($urandom), sp);
    end
    idle(4);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule